// File: doc/BRIEF.md
# Lockable Recovery Watchdog Timer

This block is a countdown watchdog for a platform security controller. The security controller (the owner, identified by a fixed master ID on the register port) programs a timeout, starts the countdown and then locks the configuration. Once locked, nothing that runs on the protected host can stop the timer or change its timeout. The host must keep pulsing the kick strobe. Each kick reloads the counter with the programmed timeout.

If the host hangs or is subverted and the kicks stop, the counter reaches zero and the block raises a sticky reset request toward the system reset controller. It also records that the watchdog caused the reset. That record survives the system reset, so the recovery flow can read why it was entered. The lock, the enable and the timeout also survive a system reset. Only a power-on reset clears them.

Register map (2-bit address, reads are combinational):

| Address | Register | Fields |
|---|---|---|
| 0 | control | bit 0 enable, bit 1 lock |
| 1 | reload value | the timeout |
| 2 | status | bit 0 cause, bit 1 error, bit 2 lock, bit 3 enable, bit 4 request |
| 3 | counter | read-only |

Unused bits read as zero.

Top module: `lwd_top`

## Requirements
- R1: After power-on reset, status (address 2) reads 0, the reload value (address 1) reads TIMEOUT_DEF, the counter (address 3) reads TIMEOUT_DEF, and `wdt_rst_req` and `wdt_cause` are 0.
- R2: An accepted owner write to the control register (address 0) with bit 0 = 1, made while the watchdog is disabled, loads the counter with the reload value at that clock edge. From then on the counter drops by one per cycle. In a cycle where the counter is 0 and no kick is present, `wdt_rst_req` rises at the next edge.
- R3: While enabled and not yet requesting, a kick reloads the counter with the reload value at the next edge. A kick in the very cycle the counter is 0 prevents the request.
- R4: Once raised, `wdt_rst_req` stays high until a system or power-on reset, whatever kicks arrive. The expiry also sets status bit 0 and `wdt_cause`.
- R5: A system reset clears `wdt_rst_req` and reloads the counter. It leaves enable, lock, the reload value and the cause bit unchanged.
- R6: A write from any master ID other than OWNER_ID, to any address, changes nothing except that it sets status bit 1 (error).
- R7: The lock bit can only be set, never cleared, by a write, and only a power-on reset clears it. While locked, owner writes to the control or reload registers are ignored and set the error bit.
- R8: An owner control write that sets lock (bit 1) with enable (bit 0) at 0 is rejected whole and sets the error bit.
- R9: An owner write to status clears the cause bit where data bit 0 is 1 and the error bit where data bit 1 is 1. An expiry in the same cycle keeps the cause bit set.
- R10: Any write to the counter address (3) is ignored and sets the error bit. A reload value write by the owner before locking reads back exactly.
- R11: While disabled, the counter holds its value and kicks have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| sys_rst | input | 1 | System reset, synchronous, active high; clears the request and reloads the counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_id | input | IW | Master ID of the current access |
| bus_rdata | output | DW | Read data for `bus_addr` |
| kick | input | 1 | Rearm strobe from the host |
| wdt_rst_req | output | 1 | Sticky reset request |
| wdt_cause | output | 1 | Last reset request came from expiry |

## Verification
A table of single register writes is applied, each one after a fresh power-on reset, and then read back. The table varies the master ID, the address and the lock/enable bits. This separates three cases: a write rejected for ownership, a write rejected for locking, and a write to a read-only location.

Directed sequences use a small timeout to pin the expiry to the exact edge and so expose off-by-one counting. Kicks are applied both in the middle of the count and in the zero cycle, which separates reload behaviour from expiry priority. A locked configuration is then carried through a system reset and then through a power-on reset, which shows which state each reset is allowed to clear.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_LOCK_BIT = 1;
    localparam int ST_CAUSE_BIT  = 0;
    localparam int ST_ERR_BIT    = 1;
    localparam int ST_W          = 5;

    typedef struct packed {
        logic ctrl_wr;
        logic start;
        logic reload_wr;
        logic clr_cause;
        logic clr_err;
        logic set_err;
    } wr_act_t;

    typedef struct packed {
        logic req;
        logic en;
        logic lock;
        logic err;
        logic cause;
    } status_t;

    function automatic logic [ST_W-1:0] pack_status(input status_t s);
        return {s.req, s.en, s.lock, s.err, s.cause};
    endfunction

endpackage

// File: rtl/lwd_gate.sv
module lwd_gate
    import lwd_pkg::*;
#(
    parameter int IW = 4,
    parameter logic [IW-1:0] OWNER_ID = '1
) (
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [1:0]    wbits,
    input  logic [IW-1:0] id,
    input  logic          lock_q,
    input  logic          en_q,
    output wr_act_t       act
);

    logic     is_owner;
    logic     bad_lock;
    reg_sel_t sel;

    assign is_owner = (id == OWNER_ID);
    assign bad_lock = wbits[CTRL_LOCK_BIT] && !wbits[CTRL_EN_BIT];
    assign sel      = reg_sel_t'(addr);

    always_comb begin
        act = '0;
        if (wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    if (is_owner && !lock_q && !bad_lock) begin
                        act.ctrl_wr = 1'b1;
                        act.start   = wbits[CTRL_EN_BIT] && !en_q;
                    end else begin
                        act.set_err = 1'b1;
                    end
                end
                SEL_RELOAD: begin
                    if (is_owner && !lock_q) act.reload_wr = 1'b1;
                    else                     act.set_err   = 1'b1;
                end
                SEL_STATUS: begin
                    if (is_owner) begin
                        act.clr_cause = wbits[ST_CAUSE_BIT];
                        act.clr_err   = wbits[ST_ERR_BIT];
                    end else begin
                        act.set_err = 1'b1;
                    end
                end
                SEL_COUNT: act.set_err = 1'b1;
                default:   act.set_err = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lwd_cfg.sv
module lwd_cfg
    import lwd_pkg::*;
#(
    parameter int DW = 16,
    parameter logic [DW-1:0] TIMEOUT_DEF = 16'd1000
) (
    input  logic          clk,
    input  logic          por,
    input  wr_act_t       act,
    input  logic [DW-1:0] wdata,
    input  logic          expire,
    output logic          en_q,
    output logic          lock_q,
    output logic [DW-1:0] reload_q,
    output logic          cause_q,
    output logic          err_q
);

    always_ff @(posedge clk) begin
        if (por) begin
            en_q     <= 1'b0;
            lock_q   <= 1'b0;
            reload_q <= TIMEOUT_DEF;
            cause_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (act.ctrl_wr) begin
                en_q   <= wdata[CTRL_EN_BIT];
                lock_q <= lock_q | wdata[CTRL_LOCK_BIT];
            end
            if (act.reload_wr) reload_q <= wdata;
            if (expire)             cause_q <= 1'b1;
            else if (act.clr_cause) cause_q <= 1'b0;
            if (act.set_err)        err_q <= 1'b1;
            else if (act.clr_err)   err_q <= 1'b0;
        end
    end

    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (por)
        (lock_q && !por) |=> lock_q) else $error("lock dropped"); // R7
    AST_EN_PINNED: assert property (@(posedge clk) disable iff (por)
        (lock_q && !por) |=> en_q) else $error("enable dropped while locked"); // R7
    AST_RELOAD_FROZEN: assert property (@(posedge clk) disable iff (por)
        (lock_q && !por) |=> $stable(reload_q)) else $error("reload changed while locked"); // R7
    AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (por)
        (act.set_err && !por) |=> err_q) else $error("rejected write not flagged"); // R6
    AST_EXPIRY_CAUSE: assert property (@(posedge clk) disable iff (por)
        (expire && !por) |=> cause_q) else $error("expiry cause lost"); // R9

endmodule

// File: rtl/lwd_count.sv
module lwd_count #(
    parameter int DW = 16,
    parameter logic [DW-1:0] TIMEOUT_DEF = 16'd1000
) (
    input  logic          clk,
    input  logic          por,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic          kick,
    input  logic [DW-1:0] reload,
    output logic [DW-1:0] cnt,
    output logic          req,
    output logic          expire
);

    logic at_zero;
    logic live;

    assign at_zero = (cnt == '0);
    assign live    = en && !req && !por && !rst;
    assign expire  = live && at_zero && !kick && !start;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt <= TIMEOUT_DEF;
            req <= 1'b0;
        end else if (rst) begin
            cnt <= reload;
            req <= 1'b0;
        end else if (start) begin
            cnt <= reload;
        end else if (en && !req) begin
            if (kick)          cnt <= reload;
            else if (!at_zero) cnt <= cnt - 1'b1;
            else               req <= 1'b1;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (por || rst)
        (req && !por && !rst) |=> req) else $error("request released"); // R4
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (por || rst)
        (en && kick && !req && !por && !rst) |=> !req) else $error("kick lost to expiry"); // R3
    AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (por || rst)
        (en && kick && !req && !start && !por && !rst) |=> (cnt == $past(reload)))
        else $error("kick did not reload"); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (por || rst)
        (!en && !start && !por && !rst) |=> $stable(cnt)) else $error("counter moved while off"); // R11
    AST_ZERO_EXPIRES: assert property (@(posedge clk) disable iff (por || rst)
        (expire) |=> req) else $error("expiry missed"); // R2

endmodule

// File: rtl/lwd_top.sv
module lwd_top
    import lwd_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 4,
    parameter logic [IW-1:0] OWNER_ID = 4'hA,
    parameter logic [DW-1:0] TIMEOUT_DEF = 16'd1000
) (
    input  logic          clk,
    input  logic          por,
    input  logic          sys_rst,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [IW-1:0] bus_id,
    output logic [DW-1:0] bus_rdata,
    input  logic          kick,
    output logic          wdt_rst_req,
    output logic          wdt_cause
);

    localparam int PAD_W = DW - ST_W;

    wr_act_t       act;
    logic          en_q, lock_q, cause_q, err_q;
    logic [DW-1:0] reload_q;
    logic [DW-1:0] cnt;
    logic          req, expire;
    status_t       st;
    reg_sel_t      rsel;

    lwd_gate #(.IW(IW), .OWNER_ID(OWNER_ID)) gate_i (
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wbits  (bus_wdata[1:0]),
        .id     (bus_id),
        .lock_q (lock_q),
        .en_q   (en_q),
        .act    (act)
    );

    lwd_cfg #(.DW(DW), .TIMEOUT_DEF(TIMEOUT_DEF)) cfg_i (
        .clk      (clk),
        .por      (por),
        .act      (act),
        .wdata    (bus_wdata),
        .expire   (expire),
        .en_q     (en_q),
        .lock_q   (lock_q),
        .reload_q (reload_q),
        .cause_q  (cause_q),
        .err_q    (err_q)
    );

    lwd_count #(.DW(DW), .TIMEOUT_DEF(TIMEOUT_DEF)) count_i (
        .clk    (clk),
        .por    (por),
        .rst    (sys_rst),
        .en     (en_q),
        .start  (act.start),
        .kick   (kick),
        .reload (reload_q),
        .cnt    (cnt),
        .req    (req),
        .expire (expire)
    );

    assign st   = '{req: req, en: en_q, lock: lock_q, err: err_q, cause: cause_q};
    assign rsel = reg_sel_t'(bus_addr);

    always_comb begin
        unique case (rsel)
            SEL_CTRL:   bus_rdata = {{(DW-2){1'b0}}, lock_q, en_q};
            SEL_RELOAD: bus_rdata = reload_q;
            SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, pack_status(st)};
            SEL_COUNT:  bus_rdata = cnt;
            default:    bus_rdata = '0;
        endcase
    end

    assign wdt_rst_req = req;
    assign wdt_cause   = cause_q;

    AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (por || sys_rst)
        (bus_wr && bus_id != OWNER_ID && !por && !sys_rst) |=> ($stable(en_q) && $stable(reload_q) && $stable(lock_q)))
        else $error("foreign write took effect"); // R6
    AST_SYSRST_KEEPS: assert property (@(posedge clk) disable iff (por)
        (sys_rst && !bus_wr && !por) |=> (!req && $stable(lock_q) && $stable(reload_q)))
        else $error("system reset disturbed config"); // R5

endmodule

// File: tb/lwd_top_tb_top.sv
`timescale 1ns/100ps
module lwd_top_tb_top;

    localparam int DW = 16;
    localparam int IW = 4;
    localparam logic [IW-1:0] OWN = 4'hA;
    localparam logic [IW-1:0] FOE = 4'h3;
    localparam logic [DW-1:0] TDEF = 16'd1000;

    logic          clk = 1'b0;
    logic          por = 1'b1, sys_rst = 1'b0, bus_wr = 1'b0, kick = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [IW-1:0] bus_id = '0;
    logic [DW-1:0] bus_rdata;
    logic          wdt_rst_req, wdt_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lwd_top #(.DW(DW), .IW(IW), .OWNER_ID(OWN), .TIMEOUT_DEF(TDEF)) dut_i (
        .clk(clk), .por(por), .sys_rst(sys_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_id(bus_id), .bus_rdata(bus_rdata), .kick(kick),
        .wdt_rst_req(wdt_rst_req), .wdt_cause(wdt_cause)
    );

    typedef struct packed {
        logic [3:0]  id;
        logic [1:0]  addr;
        logic [15:0] wdata;
        logic [1:0]  raddr;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'hA, 2'd1, 16'h0040, 2'd1, 16'h0040},  // R10 owner reload readback
        '{4'h3, 2'd1, 16'h0040, 2'd1, 16'h03E8},  // R6 foreign reload ignored
        '{4'h3, 2'd1, 16'h0040, 2'd2, 16'h0002},  // R6 foreign sets error
        '{4'h3, 2'd0, 16'h0001, 2'd2, 16'h0002},  // R6 foreign enable refused
        '{4'hA, 2'd0, 16'h0002, 2'd2, 16'h0002},  // R8 lock without enable
        '{4'hA, 2'd0, 16'h0003, 2'd2, 16'h000C},  // R7 lock with enable
        '{4'hA, 2'd3, 16'h0005, 2'd2, 16'h0002},  // R10 count is read-only
        '{4'hA, 2'd0, 16'h0001, 2'd3, 16'h03E8},  // R2 start loads reload
        '{4'hA, 2'd2, 16'h0003, 2'd2, 16'h0000}   // R9 clear with nothing set
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_por();
        por = 1'b1;
        tick();
        tick();
        por = 1'b0;
    endtask

    task automatic wr_reg(input logic [IW-1:0] id, input logic [1:0] a, input logic [DW-1:0] d);
        bus_id = id; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        tick();
        kick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [DW-1:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_por();
        // R1 reset state
        chk_reg("R1 status", 2'd2, 16'h0000);
        chk_reg("R1 reload", 2'd1, TDEF);
        chk_reg("R1 count", 2'd3, TDEF);
        chk("R1 req", {15'd0, wdt_rst_req}, 16'd0);
        chk("R1 cause", {15'd0, wdt_cause}, 16'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_por();
            wr_reg(VECS[v].id, VECS[v].addr, VECS[v].wdata);
            chk_reg($sformatf("table vec %0d", v), VECS[v].raddr, VECS[v].exp);
        end

        // R2 expiry timing
        do_por();
        wr_reg(OWN, 2'd1, 16'd8);
        wr_reg(OWN, 2'd0, 16'h0001);
        chk_reg("R2 start count", 2'd3, 16'd8);
        ticks(8);
        chk_reg("R2 zero count", 2'd3, 16'd0);
        chk("R2 no early req", {15'd0, wdt_rst_req}, 16'd0);
        tick();
        chk("R2 req rises", {15'd0, wdt_rst_req}, 16'd1);
        chk("R4 cause out", {15'd0, wdt_cause}, 16'd1);
        chk_reg("R4 status", 2'd2, 16'h0019);

        // R3 kick mid-count and at zero
        do_por();
        wr_reg(OWN, 2'd1, 16'd8);
        wr_reg(OWN, 2'd0, 16'h0001);
        ticks(5);
        chk_reg("R3 mid count", 2'd3, 16'd3);
        do_kick();
        chk_reg("R3 reload", 2'd3, 16'd8);
        ticks(8);
        do_kick();
        chk("R3 kick at zero", {15'd0, wdt_rst_req}, 16'd0);
        chk_reg("R3 reload at zero", 2'd3, 16'd8);

        // R11 disabled counter holds
        do_por();
        wr_reg(OWN, 2'd1, 16'd8);
        wr_reg(OWN, 2'd0, 16'h0001);
        ticks(3);
        wr_reg(OWN, 2'd0, 16'h0000);
        chk_reg("R11 after stop", 2'd3, 16'd4);
        ticks(3);
        do_kick();
        chk_reg("R11 held with kick", 2'd3, 16'd4);

        // R9 same-cycle expiry beats clear
        do_por();
        wr_reg(OWN, 2'd1, 16'd8);
        wr_reg(OWN, 2'd0, 16'h0001);
        ticks(8);
        wr_reg(OWN, 2'd2, 16'h0001);
        chk_reg("R9 expiry wins", 2'd2, 16'h0019);

        // R4 R5 R7 locked flow
        do_por();
        wr_reg(OWN, 2'd1, 16'd8);
        wr_reg(OWN, 2'd0, 16'h0003);
        ticks(9);
        chk_reg("R4 locked expiry", 2'd2, 16'h001D);
        do_kick();
        do_kick();
        chk("R4 sticky", {15'd0, wdt_rst_req}, 16'd1);
        sys_rst = 1'b1;
        tick();
        sys_rst = 1'b0;
        chk("R5 req cleared", {15'd0, wdt_rst_req}, 16'd0);
        chk_reg("R5 status kept", 2'd2, 16'h000D);
        chk_reg("R5 count reload", 2'd3, 16'd8);
        wr_reg(OWN, 2'd0, 16'h0000);
        chk_reg("R7 disable refused", 2'd2, 16'h000F);
        wr_reg(OWN, 2'd1, 16'd5);
        chk_reg("R7 reload frozen", 2'd1, 16'd8);
        wr_reg(OWN, 2'd2, 16'h0003);
        chk_reg("R9 clear bits", 2'd2, 16'h000C);
        sys_rst = 1'b1;
        tick();
        sys_rst = 1'b0;
        chk_reg("R7 lock survives sysrst", 2'd2, 16'h000C);
        do_por();
        chk_reg("R7 por unlocks", 2'd2, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule